// File: doc/BRIEF.md
# Bus Hold Acknowledge Controller

This block hands the system bus over to an external master on request. The requester raises `hold_req`. The block then holds back the local bus-cycle controller through `start_block`, so that no new T1 is issued. Any cycle already running is allowed to finish, including its wait states. After that the block counts out the idle clocks, stops driving every bus group this side owns, and raises `hold_ack`. When `hold_req` is withdrawn, the acknowledge drops and the drivers come back one clock later.

The handover always runs in the same order: drain the current cycle, spend the idle clocks, then float and acknowledge. The acknowledge lasts at least two clocks before the other master may start, and it continues for as long as the request stays high. `hold_req` is sampled on the rising clock edge. A request that falls before the acknowledge has been given cancels the handover, and the bus stays with the local side.

The sequencer uses six states:
- **OWNED**: the local side drives the bus.
- **DRAIN**: a local cycle is being allowed to finish.
- **IDLE**: idle clocks before release.
- **ACKWIN**: minimum acknowledge window, bus floated.
- **HELD**: extended acknowledge.
- **RETURN**: acknowledge dropped, drivers still off.

Transitions:
- OWNED→DRAIN when the request is sampled high while `cyc_busy` is high.
- OWNED→IDLE when the request is sampled high while the bus is idle.
- DRAIN→IDLE when `cyc_busy` is sampled low.
- DRAIN→OWNED and IDLE→OWNED when the request is sampled low (cancel).
- IDLE→ACKWIN when the idle count runs out.
- ACKWIN→HELD when the window ends with the request high.
- ACKWIN→RETURN when the window ends with the request low.
- HELD→RETURN when the request is sampled low.
- RETURN→OWNED unconditionally.

Top module: `bus_handover_ctrl`

## Requirements
- R1: During and after reset, with `hold_req` low, `hold_ack` is 0, every bit of `bus_oe` is 1 and `start_block` is 0.
- R2: While `cyc_busy` is high at a sampled edge, the block keeps `hold_ack` at 0 and all of `bus_oe` at 1. Handover starts only after an edge that samples `cyc_busy` low.
- R3: `start_block` is 1 in any clock where `hold_req` is 1 and in every clock from the start of a handover until the drivers are back (states DRAIN, IDLE, ACKWIN, HELD, RETURN). It is 0 in OWNED while `hold_req` is 0.
- R4: After the edge that sees the request high on an idle bus, the next clock is an idle clock with `hold_ack` 0 and drivers on. `hold_ack` rises at the following edge. This is the second idle clock, and it applies even when the bus was idle at the time of the request.
- R5: Whenever `hold_ack` is 1, every bit of `bus_oe` is 0. In the first idle clock (before `hold_ack` rises) `bus_oe` is still all ones.
- R6: Once raised, `hold_ack` stays 1 for at least two clocks, even if `hold_req` falls at once.
- R7: `hold_ack` stays 1 for as long as `hold_req` is sampled high.
- R8: Once the two-clock window has passed, the edge that samples `hold_req` low clears `hold_ack`.
- R9: `bus_oe` returns to all ones exactly one clock after `hold_ack` falls.
- R10: If `hold_req` is sampled low in DRAIN or IDLE, the handover is cancelled. `hold_ack` never rises, `bus_oe` stays all ones, and `start_block` clears at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_req | input | 1 | Bus request from the external master |
| cyc_busy | input | 1 | High while the local cycle controller is in any clock of a cycle |
| start_block | output | 1 | Forbids the cycle controller from issuing a new T1 |
| hold_ack | output | 1 | Bus granted to the external master |
| bus_oe | output | N_OE_GRP | Driver enable per bus group (address, strobe, read/write, cache, data); 1 = drive |

## Verification
The assertions assume that the cycle controller obeys `start_block`: `cyc_busy` never rises in a clock where `start_block` is high, so no local cycle can begin once the request is seen. The release check also relies on the default two-clock acknowledge window. The bench drives `cyc_busy` only as such a controller would. It raises `cyc_busy` before or together with the request, never during a handover, and lowers it only to end that cycle. All inputs change on falling edges.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    // Sequencer states of the handover controller.
    typedef enum logic [2:0] {
        ST_OWNED  = 3'd0,   // local side drives the bus
        ST_DRAIN  = 3'd1,   // waiting for the running local cycle to end
        ST_IDLE   = 3'd2,   // idle clocks ahead of the release
        ST_ACKWIN = 3'd3,   // minimum acknowledge window, bus floated
        ST_HELD   = 3'd4,   // acknowledge held while the request persists
        ST_RETURN = 3'd5    // acknowledge dropped, drivers still off
    } bhc_state_e;

    function automatic int bhc_max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/bhc_dwell_cnt.sv
module bhc_dwell_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/bhc_seq_fsm.sv
module bhc_seq_fsm
    import bhc_pkg::*;
#(
    parameter int IDLE_CLKS    = 2,
    parameter int ACK_MIN_CLKS = 2,
    parameter int CNT_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_req,
    input  logic             cyc_busy,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_dec,
    output logic             float_nxt,
    output logic             ack_q,
    output logic             block_o
);

    // Idle clocks spent in IDLE: all but the last, which is the first ACKWIN clock.
    localparam logic [CNT_W-1:0] IDLE_LOAD = CNT_W'(IDLE_CLKS - 2);
    localparam logic [CNT_W-1:0] ACK_LOAD  = CNT_W'(ACK_MIN_CLKS - 1);

    bhc_state_e state_q;
    bhc_state_e state_nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OWNED;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next-state and dwell-counter control.
    always_comb begin
        state_nxt = state_q;
        cnt_load  = 1'b0;
        cnt_val   = IDLE_LOAD;
        cnt_dec   = 1'b0;
        unique case (state_q)
            ST_OWNED: begin
                if (hold_req && cyc_busy) begin
                    state_nxt = ST_DRAIN;
                end else if (hold_req) begin
                    state_nxt = ST_IDLE;
                    cnt_load  = 1'b1;
                    cnt_val   = IDLE_LOAD;
                end
            end
            ST_DRAIN: begin
                if (!hold_req) begin
                    state_nxt = ST_OWNED;
                end else if (!cyc_busy) begin
                    state_nxt = ST_IDLE;
                    cnt_load  = 1'b1;
                    cnt_val   = IDLE_LOAD;
                end
            end
            ST_IDLE: begin
                if (!hold_req) begin
                    state_nxt = ST_OWNED;
                end else if (cnt_zero) begin
                    state_nxt = ST_ACKWIN;
                    cnt_load  = 1'b1;
                    cnt_val   = ACK_LOAD;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_ACKWIN: begin
                if (cnt_zero) begin
                    state_nxt = hold_req ? ST_HELD : ST_RETURN;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_HELD: begin
                if (!hold_req) begin
                    state_nxt = ST_RETURN;
                end
            end
            ST_RETURN: begin
                state_nxt = ST_OWNED;
            end
            default: begin
                state_nxt = ST_OWNED;
            end
        endcase
    end

    // Output register: acknowledge follows the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= (state_nxt == ST_ACKWIN) || (state_nxt == ST_HELD);
        end
    end

    assign float_nxt = (state_nxt == ST_ACKWIN) || (state_nxt == ST_HELD)
                     || (state_nxt == ST_RETURN);

    // A pending request blocks a new T1 in the same clock it is seen.
    assign block_o = hold_req || (state_q != ST_OWNED);

    // R10: a request sampled low before the window leaves no acknowledge behind.
    assert_cancel_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DRAIN || state_q == ST_IDLE) && !hold_req) |=> (state_q == ST_OWNED) && !ack_q);

    // R2: the sequencer leaves DRAIN only once the cycle is over or the request is gone.
    assert_drain_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && cyc_busy && hold_req) |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/bhc_oe_fanout.sv
module bhc_oe_fanout #(
    parameter int N_GRP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             float_nxt,
    output logic [N_GRP-1:0] oe_o
);

    // One flop per bus group so each driver bank gets its own local enable.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oe_o[g] <= 1'b1;
            end else begin
                oe_o[g] <= !float_nxt;
            end
        end
    end

endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl
    import bhc_pkg::*;
#(
    parameter int N_OE_GRP     = 5,
    parameter int IDLE_CLKS    = 2,
    parameter int ACK_MIN_CLKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold_req,
    input  logic                cyc_busy,
    output logic                start_block,
    output logic                hold_ack,
    output logic [N_OE_GRP-1:0] bus_oe
);

    localparam int CNT_MAX = bhc_max3(IDLE_CLKS - 2, ACK_MIN_CLKS - 1, 1);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_dec;
    logic             cnt_zero;
    logic             float_nxt;

    bhc_seq_fsm #(
        .IDLE_CLKS    (IDLE_CLKS),
        .ACK_MIN_CLKS (ACK_MIN_CLKS),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .cyc_busy  (cyc_busy),
        .cnt_zero  (cnt_zero),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cnt_dec   (cnt_dec),
        .float_nxt (float_nxt),
        .ack_q     (hold_ack),
        .block_o   (start_block)
    );

    bhc_dwell_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    bhc_oe_fanout #(
        .N_GRP (N_OE_GRP)
    ) u_oe (
        .clk       (clk),
        .rst_n     (rst_n),
        .float_nxt (float_nxt),
        .oe_o      (bus_oe)
    );

    // R2: no acknowledge and full drive while a local cycle is running.
    assert_busy_keeps_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_busy |-> (!hold_ack && (bus_oe == '1)));

    // R3: a visible request or an active grant always blocks new local cycles.
    assert_block_on_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req || hold_ack) |-> start_block);

    // R4: acknowledge rises only after two clocks with the bus idle.
    assert_two_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> (!$past(cyc_busy, 1) && !$past(cyc_busy, 2) && $past(start_block, 1)));

    // R5: drivers are off whenever the acknowledge is given.
    assert_float_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (bus_oe == '0));

    // R6: the acknowledge window is at least two clocks.
    assert_ack_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |=> hold_ack);

    // R7: acknowledge persists while the request is held.
    assert_ack_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && hold_req) |=> hold_ack);

    // R8: after the window, a dropped request clears the acknowledge.
    assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && $past(hold_ack) && !hold_req) |=> !hold_ack);

    // R9: drivers stay off in the clock the acknowledge falls, then come back.
    assert_oe_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> ((bus_oe == '0) ##1 (bus_oe == '1)));

endmodule

// File: tb/test_bus_handover_ctrl.sv
module test_bus_handover_ctrl;

    localparam int NG = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold_req = 1'b0;
    logic          cyc_busy = 1'b0;
    logic          start_block;
    logic          hold_ack;
    logic [NG-1:0] bus_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_handover_ctrl #(.N_OE_GRP(NG)) i_bus_handover_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_req    (hold_req),
        .cyc_busy    (cyc_busy),
        .start_block (start_block),
        .hold_ack    (hold_ack),
        .bus_oe      (bus_oe)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance one rising edge and look just after it.
    task automatic edge_look();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic h, input logic b);
        @(negedge clk);
        hold_req = h;
        cyc_busy = b;
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "ack in reset", int'(hold_ack), 0);
        chk("R1", "oe in reset", int'(bus_oe), 31);
        @(negedge clk);
        rst_n = 1'b1;
        edge_look();
        chk("R1", "ack after reset", int'(hold_ack), 0);
        chk("R1", "oe after reset", int'(bus_oe), 31);
        chk("R1", "block after reset", int'(start_block), 0);
    endtask

    task automatic t_idle_bus();
        drive(1'b1, 1'b0);
        chk("R3", "block on request", int'(start_block), 1);
        edge_look();
        chk("R4", "first idle ack", int'(hold_ack), 0);
        chk("R5", "first idle oe", int'(bus_oe), 31);
        edge_look();
        chk("R4", "ack in second idle", int'(hold_ack), 1);
        chk("R5", "oe floated", int'(bus_oe), 0);
        edge_look();
        chk("R6", "ack second clock", int'(hold_ack), 1);
        edge_look();
        chk("R7", "ack held", int'(hold_ack), 1);
        edge_look();
        chk("R7", "ack still held", int'(hold_ack), 1);
        drive(1'b0, 1'b0);
        edge_look();
        chk("R8", "ack released", int'(hold_ack), 0);
        chk("R9", "oe still off", int'(bus_oe), 0);
        chk("R3", "block in return", int'(start_block), 1);
        edge_look();
        chk("R9", "oe back", int'(bus_oe), 31);
        chk("R3", "block cleared", int'(start_block), 0);
    endtask

    task automatic t_busy_bus();
        drive(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            edge_look();
            chk("R2", "ack while busy", int'(hold_ack), 0);
            chk("R2", "oe while busy", int'(bus_oe), 31);
            chk("R3", "block while draining", int'(start_block), 1);
        end
        drive(1'b1, 1'b0);
        edge_look();
        chk("R4", "idle after drain", int'(hold_ack), 0);
        edge_look();
        chk("R4", "ack after drain", int'(hold_ack), 1);
        drive(1'b0, 1'b0);
        edge_look();
        chk("R6", "ack kept in window", int'(hold_ack), 1);
        chk("R5", "oe off in window", int'(bus_oe), 0);
        edge_look();
        chk("R8", "ack released after window", int'(hold_ack), 0);
        edge_look();
        chk("R9", "oe back after window", int'(bus_oe), 31);
    endtask

    task automatic t_cancel_idle();
        drive(1'b1, 1'b0);
        edge_look();
        drive(1'b0, 1'b0);
        edge_look();
        chk("R10", "no ack after cancel", int'(hold_ack), 0);
        chk("R10", "oe after cancel", int'(bus_oe), 31);
        chk("R10", "block after cancel", int'(start_block), 0);
        edge_look();
        chk("R10", "still no ack", int'(hold_ack), 0);
    endtask

    task automatic t_cancel_drain();
        drive(1'b1, 1'b1);
        edge_look();
        drive(1'b0, 1'b1);
        chk("R3", "block in drain without request", int'(start_block), 1);
        edge_look();
        chk("R10", "block after drain cancel", int'(start_block), 0);
        drive(1'b0, 1'b0);
        edge_look();
        edge_look();
        chk("R10", "no ack after drain cancel", int'(hold_ack), 0);
        chk("R10", "oe after drain cancel", int'(bus_oe), 31);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                t_reset();
                t_idle_bus();
                t_busy_bus();
                t_cancel_idle();
                t_cancel_drain();
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL watchdog: actual=timeout expected=completion");
                end
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule